// File: doc/BRIEF.md
# Programmable PWM Channel with Pulse-Width Capture

This block is one timer channel with a 32-bit counter. The counter advances on a tick that comes from the bus clock through two division stages in series. The first stage divides by a power of two. The second stage divides by an integer. The channel has three modes. In continuous mode it produces a repeating waveform from a period and a duty value. In one-shot mode it produces a set number of periods, then goes idle and clears its own enable. In capture mode it measures how long an external input stays high and how long it stays low.

Software controls the channel through a small write port with four word addresses: control, period, duty and status. The measured spans, the enable state and a sticky interrupt flag appear directly on output ports. New period and duty values written while the channel runs wait for the end of the current period, so no period is ever cut short or stretched.

Top module: `pwm_capture_chan`

## Requirements
- R1: After synchronous reset, `pwm_out`, `irq` and `running` are 0 and both capture outputs are 0. The polarity bit resets to 1.
- R2: Control word (address 0) fields are: bit 0 enable, bits 2:1 mode (0 continuous, 1 one-shot, 2 capture, 3 acts as continuous), bit 3 polarity, bits 7:4 exponent e, bits 15:8 scale s, bits 23:16 repeat r. The counter ticks once every 2^e*(s+1) clocks. Any write to the control word restarts both division stages and clears the counter.
- R3: In an output mode, with period P (address 1) and duty D (address 2), let the enabling control write occur at clock edge E0. At edge E(j+1) the output takes the active level when floor(j/N) mod P < D, and the inactive level otherwise, where N = 2^e*(s+1). D=0 gives a constant inactive level. D>=P gives a constant active level.
- R4: Polarity 1 makes the duty portion high and the idle level low. Polarity 0 inverts both.
- R5: Period or duty writes made while running take effect at the next period boundary. The counter never reaches the active period.
- R6: In one-shot mode the channel emits r+1 periods. It then drives the inactive level, `running` falls and `irq` is set.
- R7: In capture mode the input passes through a two-stage synchronizer. A falling edge latches the length of the preceding high span, in ticks, into `cap_high`. A rising edge latches the length of the preceding low span into `cap_low`. Each edge clears the counter and sets `irq`. With N=1 a span of H clocks reads exactly H.
- R8: `irq` is set at every period boundary and every capture edge. It stays set until a status write (address 3) with bit 0 at 1. A status write with bit 0 at 0 leaves it unchanged.
- R9: While disabled or in capture mode, `pwm_out` holds the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address: 0 control, 1 period, 2 duty, 3 status |
| wr_data | input | 32 | Write data |
| cap_in | input | 1 | External input measured in capture mode |
| pwm_out | output | 1 | Registered waveform output |
| irq | output | 1 | Sticky interrupt flag |
| running | output | 1 | Current enable bit |
| cap_high | output | 32 | Last measured high span in ticks |
| cap_low | output | 32 | Last measured low span in ticks |

## Verification
The bench keeps the default widths: a 32-bit counter, a 4-bit exponent, an 8-bit scale and an 8-bit repeat count. It drives only small periods (1 to 6), duties (0 to 5), exponents 0 to 2, scales 0 to 2 and repeat counts 0 to 3. With values this small, every output sample of each combination can be computed from the floor-and-modulo formula and compared cycle by cycle. That range covers the duty-zero and duty-at-or-above-period edges, divisors from 1 to 12, the exact end of a one-shot run, the boundary at which a rewritten period takes effect, and capture spans as short as a single clock.

// File: rtl/pwm_cap_pkg.sv
package pwm_cap_pkg;
  typedef enum logic [1:0] {
    MODE_CONT    = 2'd0,
    MODE_ONESHOT = 2'd1,
    MODE_CAPTURE = 2'd2,
    MODE_RSVD    = 2'd3
  } pwm_mode_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DUTY   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd3;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int EXP_W   = 4,
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic [EXP_W-1:0]   exp_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               tick_o
);
  localparam int STG1_W = 1 << EXP_W;

  logic [STG1_W-1:0]  pre_cnt;
  logic [STG1_W-1:0]  mask;
  logic [SCALE_W-1:0] sc_cnt;
  logic               stg1;

  assign mask   = (STG1_W'(1) << exp_i) - STG1_W'(1);
  assign stg1   = ((pre_cnt & mask) == mask);
  assign tick_o = stg1 && (sc_cnt == scale_i);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_cnt <= '0;
      sc_cnt  <= '0;
    end else begin
      pre_cnt <= pre_cnt + STG1_W'(1);
      if (stg1) sc_cnt <= (sc_cnt == scale_i) ? '0 : sc_cnt + SCALE_W'(1);
    end
  end

  // R2: with any divisor above one, two ticks are never adjacent
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick_o && !clr && (exp_i != '0 || scale_i != '0)) |=> !tick_o);
endmodule

// File: rtl/pwm_in_edge.sv
module pwm_in_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_STAGES-1:0], sig_i};
  end

  assign rise_o = sh[SYNC_STAGES-1] && !sh[SYNC_STAGES];
  assign fall_o = !sh[SYNC_STAGES-1] && sh[SYNC_STAGES];

  // R7: a detected rising edge lasts exactly one cycle
  a_r7_single_rise: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_en,
  input  logic             pol_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o
);
  always_ff @(posedge clk) begin
    if (rst)            pwm_o <= 1'b0;
    else if (active_en) pwm_o <= (cnt_i < duty_i) ? pol_i : !pol_i;
    else                pwm_o <= !pol_i;
  end

  // R9: outside an output mode the pin settles to the idle level
  a_r9_idle_level: assert property (@(posedge clk) disable iff (rst)
    !active_en |=> (pwm_o == !$past(pol_i)));
endmodule

// File: rtl/pwm_capture_chan.sv
module pwm_capture_chan
  import pwm_cap_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int EXP_W       = 4,
  parameter int SCALE_W     = 8,
  parameter int RPT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              cap_in,
  output logic              pwm_out,
  output logic              irq,
  output logic              running,
  output logic [CNT_W-1:0]  cap_high,
  output logic [CNT_W-1:0]  cap_low
);
  localparam int EN_B      = 0;
  localparam int MODE_LSB  = 1;
  localparam int POL_B     = 3;
  localparam int EXP_LSB   = 4;
  localparam int SCALE_LSB = EXP_LSB + EXP_W;
  localparam int RPT_LSB   = SCALE_LSB + SCALE_W;

  logic               en_q, pol_q, irq_q;
  pwm_mode_e          mode_q;
  logic [EXP_W-1:0]   exp_q;
  logic [SCALE_W-1:0] scale_q;
  logic [RPT_W-1:0]   rep_left;
  logic [CNT_W-1:0]   per_reg, duty_reg, per_act, duty_act, cnt;
  logic [CNT_W-1:0]   cap_high_q, cap_low_q;

  logic tick, rise, fall, wr_ctrl, out_mode, clr, boundary, oneshot_done, cap_evt;

  assign wr_ctrl      = wr_en && (wr_addr == ADDR_CTRL);
  assign out_mode     = (mode_q != MODE_CAPTURE);
  assign clr          = !en_q || wr_ctrl;
  assign boundary     = en_q && out_mode && tick && (cnt == per_act - CNT_W'(1));
  assign oneshot_done = boundary && (mode_q == MODE_ONESHOT) && (rep_left == '0);
  assign cap_evt      = en_q && !out_mode && (rise || fall);

  pwm_prescaler #(.EXP_W(EXP_W), .SCALE_W(SCALE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(clr), .exp_i(exp_q), .scale_i(scale_q), .tick_o(tick)
  );

  pwm_in_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .sig_i(cap_in), .rise_o(rise), .fall_o(fall)
  );

  pwm_wave #(.CNT_W(CNT_W)) u_wave (
    .clk(clk), .rst(rst), .active_en(en_q && out_mode), .pol_i(pol_q),
    .cnt_i(cnt), .duty_i(duty_act), .pwm_o(pwm_out)
  );

  // control fields and self-clearing enable
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      mode_q  <= MODE_CONT;
      pol_q   <= 1'b1;
      exp_q   <= '0;
      scale_q <= '0;
    end else if (wr_ctrl) begin
      en_q    <= wr_data[EN_B];
      mode_q  <= pwm_mode_e'(wr_data[MODE_LSB +: 2]);
      pol_q   <= wr_data[POL_B];
      exp_q   <= wr_data[EXP_LSB +: EXP_W];
      scale_q <= wr_data[SCALE_LSB +: SCALE_W];
    end else if (oneshot_done) begin
      en_q <= 1'b0;
    end
  end

  // staged period/duty and active copies
  always_ff @(posedge clk) begin
    if (rst) begin
      per_reg  <= '0;
      duty_reg <= '0;
      per_act  <= '0;
      duty_act <= '0;
      rep_left <= '0;
    end else begin
      if (wr_en && wr_addr == ADDR_PERIOD) per_reg  <= wr_data;
      if (wr_en && wr_addr == ADDR_DUTY)   duty_reg <= wr_data;
      if (!en_q || boundary) begin
        per_act  <= per_reg;
        duty_act <= duty_reg;
      end
      if (wr_ctrl)                         rep_left <= wr_data[RPT_LSB +: RPT_W];
      else if (boundary && rep_left != '0) rep_left <= rep_left - RPT_W'(1);
    end
  end

  // shared counter, capture latches, interrupt flag
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      cap_high_q <= '0;
      cap_low_q  <= '0;
      irq_q      <= 1'b0;
    end else begin
      if (clr || cap_evt || boundary) cnt <= '0;
      else if (tick)                  cnt <= cnt + CNT_W'(1);
      if (cap_evt) begin
        if (rise) cap_low_q  <= cnt + CNT_W'(tick);
        else      cap_high_q <= cnt + CNT_W'(tick);
      end
      if (boundary || cap_evt)                                irq_q <= 1'b1;
      else if (wr_en && wr_addr == ADDR_STATUS && wr_data[0]) irq_q <= 1'b0;
    end
  end

  assign irq      = irq_q;
  assign running  = en_q;
  assign cap_high = cap_high_q;
  assign cap_low  = cap_low_q;

  // R3: the counter stays inside the active period
  a_r3_cnt_in_period: assert property (@(posedge clk) disable iff (rst)
    (en_q && out_mode && per_act != '0) |-> (cnt < per_act));
  // R5: active period/duty change only at a boundary while running
  a_r5_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    (en_q && !boundary) |=> ($stable(per_act) && $stable(duty_act)));
  // R6: the self-clear of the enable always raises the flag
  a_r6_done_irq: assert property (@(posedge clk) disable iff (rst)
    ($fell(en_q) && !$past(wr_ctrl)) |-> irq_q);
  // R7: a capture edge sets the flag on the next cycle
  a_r7_cap_irq: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> irq_q);
endmodule

// File: tb/sim_pwm_capture_chan.sv
module sim_pwm_capture_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        cap_in = 1'b0;
  logic        pwm_out, irq, running;
  logic [31:0] cap_high, cap_low;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  pwm_capture_chan u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_in(cap_in), .pwm_out(pwm_out), .irq(irq), .running(running),
    .cap_high(cap_high), .cap_low(cap_low)
  );

  task automatic chk(input string req, input longint act, input longint expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  // drive at the current falling edge, return at the next falling edge
  task automatic step(input bit we, input logic [1:0] a, input logic [31:0] d);
    wr_en = we; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, 2'd0, 32'd0);
  endtask

  function automatic logic [31:0] ctrl_word(input int en, input int mode, input int pol,
                                            input int e, input int s, input int r);
    return 32'(en) | (32'(mode) << 1) | (32'(pol) << 3) | (32'(e) << 4) |
           (32'(s) << 8) | (32'(r) << 16);
  endfunction

  // R3/R4/R6: prepare, enable, then compare every sample with the formula
  task automatic run_wave(input int mode, input int pol, input int e, input int s,
                          input int p, input int d, input int r, input int nsamp,
                          input string tag);
    int n, lim, expv;
    n   = (1 << e) * (s + 1);
    lim = (mode == 1) ? (r + 1) * p * n : 32'h7fffffff;
    step(1'b1, 2'd0, ctrl_word(0, mode, pol, e, s, r));
    step(1'b1, 2'd1, 32'(p));
    step(1'b1, 2'd2, 32'(d));
    step(1'b1, 2'd3, 32'd1);
    step(1'b1, 2'd0, ctrl_word(1, mode, pol, e, s, r));
    for (int j = 0; j < nsamp; j++) begin
      idle();
      if (j < lim) expv = (((j / n) % p) < d) ? pol : 1 - pol;
      else         expv = 1 - pol;
      chk(tag, pwm_out, expv);
    end
  endtask

  task automatic run_cap(input int e, input int h, input int l, input int eh, input int el);
    step(1'b1, 2'd0, ctrl_word(0, 2, 1, e, 0, 0));
    step(1'b1, 2'd3, 32'd1);
    step(1'b1, 2'd0, ctrl_word(1, 2, 1, e, 0, 0));
    cap_in = 1'b1;
    repeat (h) idle();
    cap_in = 1'b0;
    repeat (l) idle();
    cap_in = 1'b1;
    repeat (4) idle();
    chk("R7 high span", cap_high, eh);
    chk("R7 low span", cap_low, el);
    chk("R8 capture flag", irq, 1);
    chk("R9 idle in capture", pwm_out, 0);
    cap_in = 1'b0;
    repeat (4) idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pwm_out", pwm_out, 0);
    chk("R1 irq", irq, 0);
    chk("R1 running", running, 0);
    chk("R1 cap_high", cap_high, 0);
    chk("R1 cap_low", cap_low, 0);
    rst = 1'b0;
    idle();
    chk("R9 disabled level", pwm_out, 0);

    // R3/R4: continuous sweep, undivided tick
    for (int pol = 0; pol < 2; pol++)
      for (int p = 1; p <= 4; p++)
        for (int d = 0; d <= 5; d++) begin
          run_wave(0, pol, 0, 0, p, d, 0, 2 * p + 2, "R3/R4 continuous");
          chk("R8 period flag", irq, 1);
        end

    // R2: two-stage divisor sweep
    for (int e = 0; e <= 2; e++)
      for (int s = 0; s <= 2; s++)
        run_wave(0, 1, e, s, 3, 1, 0, 6 * (1 << e) * (s + 1), "R2 prescale");

    // R6: one-shot runs of r+1 periods
    for (int r = 0; r <= 3; r++) begin
      run_wave(1, 1, 1, 0, 3, 2, r, (r + 1) * 6 + 3, "R6 one-shot");
      chk("R6 running cleared", running, 0);
      chk("R6 done flag", irq, 1);
    end

    // R5: new period/duty wait for the boundary at sample 8
    run_wave(0, 1, 0, 0, 4, 1, 0, 4, "R5 before rewrite");
    for (int j = 4; j < 20; j++) begin
      int expv;
      if (j == 4)      step(1'b1, 2'd1, 32'd6);
      else if (j == 5) step(1'b1, 2'd2, 32'd3);
      else             idle();
      expv = (j < 8) ? ((j % 4) < 1) : (((j - 8) % 6) < 3);
      chk("R5 shadow update", pwm_out, expv);
    end

    // R7: capture spans, undivided tick
    for (int h = 1; h <= 5; h++)
      for (int l = 1; l <= 4; l++)
        run_cap(0, h, l, h, l);
    // R7: capture with divide-by-two tick
    run_cap(1, 6, 4, 3, 2);

    // R8: status write of 0 leaves flag, write of 1 clears it
    step(1'b1, 2'd3, 32'd0);
    chk("R8 write zero ignored", irq, 1);
    step(1'b1, 2'd3, 32'd1);
    chk("R8 write one clears", irq, 0);
    step(1'b1, 2'd0, ctrl_word(0, 0, 0, 0, 0, 0));
    idle();
    chk("R4 idle level pol 0", pwm_out, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule